// File: doc/BRIEF.md
# Clock Input Holdover Mode Controller

This block supervises the operating mode of a digital PLL. It watches a set of per-input clock-valid flags, the index of the input the loop currently tracks, and the lock indication reported by the loop. From these it decides whether the loop is acquiring, locked, in holdover or re-acquiring after holdover. It drives the lock status, the holdover flag, a one-cycle freeze strobe that makes the frequency-history averager hold its final value, and a one-cycle start strobe for the exit ramp generator.

Holdover is a last resort. When the tracked input fails and some other input is still valid, the block raises an input-switch request that names the lowest-numbered valid input, and it drops back to acquiring. It enters holdover only when no input at all is valid. When any input returns, the block leaves holdover and re-acquires. The exit is either ramped, which is what a tied-low configuration pin gives, or handed to the loop. In the second case a further configuration bit chooses between the normal loop bandwidth and a dedicated holdover-exit bandwidth.

Top module: `holdover_ctrl`

## Requirements
- R1: After reset, mode is 00 (acquiring), and lock_ok, holdover_active, freeze_stb, ramp_start_stb and exit_bw_alt are all 0.
- R2: In acquiring, or in re-acquiring (11), the mode becomes 01 (locked) one clock after an edge at which the tracked input is valid and loop_locked is 1. lock_ok is 1 exactly while mode is 01.
- R3: In locked, if loop_locked is 0 while the tracked input is valid, or if the tracked input is invalid while another input is valid, the mode returns to 00 at the next edge.
- R4: In locked, if no clk_valid bit is set, the mode becomes 10 (holdover) at the next edge and holdover_active is 1. freeze_stb is 1 for exactly the first cycle of that holdover.
- R5: Whenever the tracked input is invalid and at least one clk_valid bit is set, switch_req is 1 in the same cycle and switch_idx gives the lowest set clk_valid bit. Otherwise switch_req is 0 and switch_idx is 0.
- R6: In holdover, the mode becomes 11 (re-acquiring) at the first edge where any clk_valid bit is set. If cfg_direct_exit was 0 at that edge, ramp_start_stb is 1 for exactly the first re-acquiring cycle.
- R7: If cfg_direct_exit was 1 at the holdover exit edge, no ramp strobe is issued. exit_bw_alt is then 1 throughout that re-acquiring stay if cfg_alt_bw was 1 at that edge. In every other case exit_bw_alt is 0.
- R8: In re-acquiring, if every clk_valid bit clears, the mode returns to 10 without a freeze strobe.
- R9: A sel_idx value of N_INPUTS or above counts as an invalid tracked input.
- R10: Holdover is reached only from locked or re-acquiring. In acquiring with no valid input, the mode stays 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_valid | input | N_INPUTS | Per-input clock-valid flags |
| sel_idx | input | IDX_W | Index of the input the loop tracks |
| loop_locked | input | 1 | Phase and frequency lock reported by the loop |
| cfg_direct_exit | input | 1 | 0: ramped holdover exit; 1: exit handed to the loop |
| cfg_alt_bw | input | 1 | With direct exit, 1 selects the holdover-exit bandwidth |
| mode | output | 2 | 00 acquiring, 01 locked, 10 holdover, 11 re-acquiring |
| lock_ok | output | 1 | Lock status, high only in locked |
| holdover_active | output | 1 | High in holdover |
| freeze_stb | output | 1 | One-cycle strobe on holdover entry |
| ramp_start_stb | output | 1 | One-cycle strobe starting the exit ramp |
| exit_bw_alt | output | 1 | Loop should use the holdover-exit bandwidth |
| switch_req | output | 1 | Request to switch to another valid input |
| switch_idx | output | IDX_W | Input to switch to |

## Verification
The bench builds the block with N_INPUTS = 3, so IDX_W is 2. The index value 3 then names no input, which tests the rule that an out-of-range index is an invalid tracked input (R9). With only three flags, a random draw often leaves every flag clear. This makes holdover entry, and the return from re-acquiring to holdover, common under random stimulus. The lowest-valid-input choice can also be checked with every flag pattern.

// File: rtl/holdover_ctrl.sv
module holdover_ctrl #(
  parameter int N_INPUTS = 4,
  localparam int IDX_W = (N_INPUTS > 1) ? $clog2(N_INPUTS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_INPUTS-1:0] clk_valid,
  input  logic [IDX_W-1:0]    sel_idx,
  input  logic                loop_locked,
  input  logic                cfg_direct_exit,
  input  logic                cfg_alt_bw,
  output logic [1:0]          mode,
  output logic                lock_ok,
  output logic                holdover_active,
  output logic                freeze_stb,
  output logic                ramp_start_stb,
  output logic                exit_bw_alt,
  output logic                switch_req,
  output logic [IDX_W-1:0]    switch_idx
);
  localparam logic [1:0] ACQ = 2'b00, LCK = 2'b01, HLD = 2'b10, RAQ = 2'b11;

  logic [1:0] st, nxt;
  logic       sel_ok, any_ok, alt_q;

  always_comb begin
    sel_ok = 1'b0;
    for (int i = 0; i < N_INPUTS; i++)
      if (sel_idx == IDX_W'(i)) sel_ok = clk_valid[i];
  end

  assign any_ok = |clk_valid;

  always_comb begin
    switch_idx = '0;
    for (int i = N_INPUTS - 1; i >= 0; i--)
      if (clk_valid[i]) switch_idx = IDX_W'(i);
    if (sel_ok || !any_ok) switch_idx = '0;
  end

  assign switch_req = !sel_ok && any_ok;

  always_comb begin
    nxt = st;
    unique case (st)
      ACQ: if (sel_ok && loop_locked) nxt = LCK;
      LCK: if (!any_ok) nxt = HLD;
           else if (!sel_ok || !loop_locked) nxt = ACQ;
      HLD: if (any_ok) nxt = RAQ;
      RAQ: if (!any_ok) nxt = HLD;
           else if (sel_ok && loop_locked) nxt = LCK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st             <= ACQ;
      freeze_stb     <= 1'b0;
      ramp_start_stb <= 1'b0;
      alt_q          <= 1'b0;
    end else begin
      st             <= nxt;
      freeze_stb     <= (st == LCK) && (nxt == HLD);
      ramp_start_stb <= (st == HLD) && (nxt == RAQ) && !cfg_direct_exit;
      if (nxt != RAQ)      alt_q <= 1'b0;
      else if (st == HLD)  alt_q <= cfg_direct_exit && cfg_alt_bw;
    end

  assign mode            = st;
  assign lock_ok         = (st == LCK);
  assign holdover_active = (st == HLD);
  assign exit_bw_alt     = alt_q;

  p_lock_needs_loop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_ok) |-> $past(loop_locked));
  p_hold_entry_none_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(holdover_active) |-> $past(clk_valid) == '0);
  p_freeze_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_stb |=> !freeze_stb);
  p_freeze_on_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_stb |-> holdover_active);
  p_switch_target_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    switch_req |-> clk_valid[switch_idx]);
  p_ramp_after_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_start_stb |-> $past(holdover_active) && mode == RAQ);
  p_ramp_xor_alt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ramp_start_stb && exit_bw_alt));
  p_no_hold_from_acq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(holdover_active) |-> $past(mode) != ACQ);
endmodule

// File: tb/holdover_ctrl_tb.sv
module holdover_ctrl_tb;
  localparam int N = 3;
  localparam int W = 2;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] clk_valid = '0;
  logic [W-1:0] sel_idx = '0;
  logic loop_locked = 0, cfg_direct_exit = 0, cfg_alt_bw = 0;
  logic [1:0] mode;
  logic lock_ok, holdover_active, freeze_stb, ramp_start_stb, exit_bw_alt, switch_req;
  logic [W-1:0] switch_idx;

  int checks = 0, errors = 0;
  logic [1:0] e_st = 2'b00;
  logic e_alt = 0;

  holdover_ctrl #(.N_INPUTS(N)) u_dut (.*);

  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic f_sel_ok(input logic [N-1:0] v, input logic [W-1:0] s);
    return (int'(s) < N) ? v[s] : 1'b0;
  endfunction

  function automatic logic [W-1:0] f_low(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return W'(i);
    return '0;
  endfunction

  function automatic logic [1:0] f_next(input logic [1:0] s, input logic [N-1:0] v,
                                        input logic ok, input logic lk);
    case (s)
      2'b00: return (ok && lk) ? 2'b01 : 2'b00;
      2'b01: return (v == 0) ? 2'b10 : (!ok || !lk) ? 2'b00 : 2'b01;
      2'b10: return (v != 0) ? 2'b11 : 2'b10;
      default: return (v == 0) ? 2'b10 : (ok && lk) ? 2'b01 : 2'b11;
    endcase
  endfunction

  task automatic step(input logic [N-1:0] v, input logic [W-1:0] s, input logic lk,
                      input logic dx, input logic ab);
    logic ok;
    logic [1:0] n;
    logic e_frz, e_rmp;
    @(negedge clk);
    clk_valid = v; sel_idx = s; loop_locked = lk; cfg_direct_exit = dx; cfg_alt_bw = ab;
    #1;
    ok = f_sel_ok(v, s);
    chk(int'(s) >= N ? "R9 switch_req" : "R5 switch_req", switch_req, !ok && v != 0);
    chk("R5 switch_idx", switch_idx, (!ok && v != 0) ? f_low(v) : 0);
    n = f_next(e_st, v, ok, lk);
    e_frz = (e_st == 2'b01) && (n == 2'b10);
    e_rmp = (e_st == 2'b10) && (n == 2'b11) && !dx;
    if (n != 2'b11) e_alt = 0;
    else if (e_st == 2'b10) e_alt = dx && ab;
    e_st = n;
    @(posedge clk); #1;
    chk("R2 R3 R4 R6 R8 R10 mode", mode, e_st);
    chk("R2 lock_ok", lock_ok, e_st == 2'b01);
    chk("R4 holdover_active", holdover_active, e_st == 2'b10);
    chk("R4 R8 freeze_stb", freeze_stb, e_frz);
    chk("R6 R7 ramp_start_stb", ramp_start_stb, e_rmp);
    chk("R7 exit_bw_alt", exit_bw_alt, e_alt);
  endtask

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #25;
    chk("R1 mode", mode, 0);
    chk("R1 lock_ok", lock_ok, 0);
    chk("R1 holdover_active", holdover_active, 0);
    chk("R1 strobes", {freeze_stb, ramp_start_stb, exit_bw_alt}, 0);
    rst_n = 1;
    // R10: acquiring with nothing valid stays acquiring
    step(3'b000, 2'd0, 1, 0, 0);
    chk("R10 stay acquiring", mode, 0);
    // R2 lock then R4 holdover entry with freeze
    step(3'b001, 2'd0, 1, 0, 0);
    step(3'b000, 2'd0, 1, 0, 0);
    step(3'b000, 2'd0, 1, 0, 0);
    // R6 ramped exit on input 2 returning
    step(3'b100, 2'd0, 0, 0, 1);
    // R8 loss again during re-acquire
    step(3'b000, 2'd0, 0, 0, 0);
    // R7 direct exit with alternate bandwidth
    step(3'b010, 2'd1, 0, 1, 1);
    step(3'b010, 2'd1, 0, 0, 0);
    step(3'b010, 2'd1, 1, 0, 0);
    // R3 tracked input fails with another valid
    step(3'b100, 2'd1, 1, 0, 0);
    // R9 out-of-range index
    step(3'b111, 2'd3, 1, 0, 0);
    chk("R9 no lock on index 3", mode, 0);
    for (int k = 0; k < 4000; k++) begin
      logic [N-1:0] v;
      v = ($urandom % 3 == 0) ? '0 : N'($urandom);
      step(v, W'($urandom), ($urandom % 5) < 3, $urandom % 2, $urandom % 2);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule